// File: doc/BRIEF.md
# Dual CAM Slot Access Controller

This block lets a host reach two common-interface card slots through a small byte-wide register file. The host loads a 14-bit card address into two address registers. It picks the slot and the card space (attribute memory or control/IO) in a bus-control register, then touches the data register. That access runs exactly one card read or write strobe of fixed width at the latched address. The same bus-control register starts a self-clearing reset pulse for each slot, enables stream routing through each slot, and shows each slot's card-detect input, which is active low.

A second control register drives the stream-output enables and the two active-low tuner resets. An interrupt register arms the interrupt line with the pattern 0x44. A change of card presence on either slot marks an interrupt as pending. Reading that register returns the pending flag and clears it.

The host port uses a valid/ready request channel and a response strobe with no back-pressure. `req_ready` stays low for as long as a card strobe is in progress, so a request offered during that time waits. `rsp_valid` pulses for one cycle for every accepted request. The host must take the response in that cycle.

Top module: `cam_slot_ctrl`

## Requirements
- R1: The low address register (offset 4) stores written bits 7:1 as card address 6:0 and reads back with bit 0 zero. The high address register (offset 5) stores written bits 6:0 as card address 13:7 and reads back with bit 7 zero. The card address bus carries this latched address throughout a card strobe and stays stable during it.
- R2: In the bus-control register (offset 7), bit 7 selects the slot. With bit 7 at 0, a card cycle drives `card_sel_n` to 2'b10 (slot 0). With bit 7 at 1, it drives `card_sel_n` to 2'b01 (slot 1). Bit 6 drives `card_io_space` (1 selects the control/IO space). Outside a card cycle, `card_sel_n` is 2'b11.
- R3: A write to the data register (offset 6) holds `card_wr_n` low for STROBE_CYC cycles with `card_dout` equal to the written byte. `card_rd_n` stays high throughout, and `req_ready` stays low until the strobe ends.
- R4: A read of the data register holds `card_rd_n` low for STROBE_CYC cycles. `rsp_valid` rises STROBE_CYC+1 cycles after the acceptance edge, carrying the `card_din` value sampled in the last strobe cycle.
- R5: Any access to a register other than the data register starts no card strobe, and its response follows one cycle after acceptance. Unmapped offsets read as 0, and writes to them change no readable state.
- R6: Writing 1 to bus-control bit 5 (slot 0) or bit 4 (slot 1) asserts that slot's `card_rst` for RST_CYC cycles. The bit reads back as 1 while the pulse runs and as 0 afterwards. Writing 0 to these bits has no effect.
- R7: Bus-control bit 3 drives `ts_route_en[0]` and bit 2 drives `ts_route_en[1]`. Both bits read back as written.
- R8: Bus-control bit 1 reads the synchronised `card_detect_n[0]` and bit 0 reads the synchronised `card_detect_n[1]`, each with a two-flop delay.
- R9: Writing 0x44 to the interrupt register (offset 0) enables the interrupt, and writing any other value disables it. A change of either synchronised detect input sets the pending flag. `irq` equals pending AND enable. A read of offset 0 returns {0, enable, 00000, pending} and clears the pending flag.
- R10: The second control register (offset 1) reads back as written. Bit 4 drives `ts_out_en[0]` and bit 5 drives `ts_out_en[1]`. Bit 3 drives `tuner_rst_n[0]` and bit 2 drives `tuner_rst_n[1]`.
- R11: After reset, every register is zero, no strobe or slot reset is active, `irq` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request can be accepted (low during a card strobe) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register offset |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 8 | Read byte (0 for writes) |
| card_addr | output | 14 | Card address |
| card_dout | output | 8 | Byte driven to the card |
| card_din | input | 8 | Byte returned by the card |
| card_sel_n | output | 2 | Active-low slot selects |
| card_io_space | output | 1 | 1 = control/IO space, 0 = attribute memory |
| card_rd_n | output | 1 | Active-low read strobe |
| card_wr_n | output | 1 | Active-low write strobe |
| card_rst | output | 2 | Per-slot card reset pulse |
| card_detect_n | input | 2 | Per-slot card detect, low = present |
| ts_route_en | output | 2 | Per-slot stream routing enable |
| ts_out_en | output | 2 | Stream output enables |
| tuner_rst_n | output | 2 | Active-low tuner resets |
| irq | output | 1 | Interrupt request |

## Verification
A wrong strobe counter shows at the ports in the first card access: the strobe is too long or too short, or `rsp_valid` comes a cycle early or late. A corrupt address or slot latch appears on `card_addr` and `card_sel_n` during the next strobe, and in the data a card read returns. Reset-pulse and interrupt-pending faults show within one pulse length: a busy bit stays set or clears too soon, or `irq` stays high after the acknowledge read. Stimulus is seeded random card accesses over both slots and spaces, with directed cases for reset, presence changes and unmapped offsets.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int REG_AW  = 4;
  localparam int DW      = 8;
  localparam int CARD_AW = 14;
  localparam int NSLOT   = 2;

  localparam logic [REG_AW-1:0] RA_IRQ  = 4'h0;
  localparam logic [REG_AW-1:0] RA_CTL2 = 4'h1;
  localparam logic [REG_AW-1:0] RA_ALO  = 4'h4;
  localparam logic [REG_AW-1:0] RA_AHI  = 4'h5;
  localparam logic [REG_AW-1:0] RA_DATA = 4'h6;
  localparam logic [REG_AW-1:0] RA_BUS  = 4'h7;

  localparam logic [DW-1:0] IRQ_ARM = 8'h44;

  typedef enum logic {CYC_IDLE, CYC_STROBE} cyc_state_t;

  typedef struct packed {
    logic [CARD_AW-1:0] addr;
    logic [DW-1:0]      wdata;
    logic               slot;
    logic               io;
    logic               wr;
  } card_req_t;
endpackage

// File: rtl/cam_card_cycle.sv
module cam_card_cycle
  import cam_pkg::*;
#(
  parameter int STROBE_CYC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  card_req_t          req,
  input  logic [DW-1:0]      card_din,
  output logic               busy,
  output logic               done,
  output logic [DW-1:0]      rdata,
  output logic [CARD_AW-1:0] card_addr,
  output logic [DW-1:0]      card_dout,
  output logic [NSLOT-1:0]   card_sel_n,
  output logic               card_io_space,
  output logic               card_rd_n,
  output logic               card_wr_n
);
  localparam int CW = $clog2(STROBE_CYC) + 1;

  cyc_state_t      state;
  logic [CW-1:0]   cnt;
  card_req_t       q;
  logic            active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= CYC_IDLE;
      cnt   <= '0;
      q     <= '0;
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        CYC_IDLE: if (start) begin
          q     <= req;
          cnt   <= CW'(STROBE_CYC - 1);
          state <= CYC_STROBE;
        end
        default: begin
          if (cnt == '0) begin
            rdata <= q.wr ? '0 : card_din;
            done  <= 1'b1;
            state <= CYC_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  assign active        = (state == CYC_STROBE);
  assign busy          = active;
  assign card_addr     = q.addr;
  assign card_dout     = q.wdata;
  assign card_io_space = q.io;
  assign card_sel_n    = active ? (q.slot ? 2'b01 : 2'b10) : 2'b11;
  assign card_rd_n     = !(active && !q.wr);
  assign card_wr_n     = !(active && q.wr);

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~card_sel_n));
  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!card_rd_n && !card_wr_n));
  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt != '0) |=> ($stable(card_addr) && !card_sel_n[0] != !card_sel_n[1]));
endmodule

// File: rtl/cam_slot_reset.sv
module cam_slot_reset #(
  parameter int RST_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic card_rst,
  output logic busy
);
  localparam int CW = $clog2(RST_CYC) + 1;

  logic [CW-1:0] cnt;
  logic          on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on  <= 1'b0;
      cnt <= '0;
    end else if (kick) begin
      on  <= 1'b1;
      cnt <= CW'(RST_CYC - 1);
    end else if (on) begin
      if (cnt == '0) on <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign card_rst = on;
  assign busy     = on;

  // R6
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on && cnt != '0) |=> card_rst);
  // R6
  rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> card_rst);
endmodule

// File: rtl/cam_irq_ctrl.sv
module cam_irq_ctrl
  import cam_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] det_n,
  input  logic             en_wr,
  input  logic             en_val,
  input  logic             ack,
  output logic [NSLOT-1:0] present_n,
  output logic             pend,
  output logic             en,
  output logic             irq
);
  logic [NSLOT-1:0] s1, s2, s3;
  logic             change;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1   <= '1;
      s2   <= '1;
      s3   <= '1;
      pend <= 1'b0;
      en   <= 1'b0;
    end else begin
      s1 <= det_n;
      s2 <= s1;
      s3 <= s2;
      if (change)   pend <= 1'b1;
      else if (ack) pend <= 1'b0;
      if (en_wr)    en <= en_val;
    end
  end

  assign change    = (s3 != s2);
  assign present_n = s2;
  assign irq       = pend && en;

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> en);
  // R9
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ack) |=> pend);
endmodule

// File: rtl/cam_slot_ctrl.sv
module cam_slot_ctrl
  import cam_pkg::*;
#(
  parameter int STROBE_CYC = 3,
  parameter int RST_CYC    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [REG_AW-1:0]  req_addr,
  input  logic [DW-1:0]      req_wdata,
  output logic               rsp_valid,
  output logic [DW-1:0]      rsp_rdata,
  output logic [CARD_AW-1:0] card_addr,
  output logic [DW-1:0]      card_dout,
  input  logic [DW-1:0]      card_din,
  output logic [NSLOT-1:0]   card_sel_n,
  output logic               card_io_space,
  output logic               card_rd_n,
  output logic               card_wr_n,
  output logic [NSLOT-1:0]   card_rst,
  input  logic [NSLOT-1:0]   card_detect_n,
  output logic [NSLOT-1:0]   ts_route_en,
  output logic [NSLOT-1:0]   ts_out_en,
  output logic [NSLOT-1:0]   tuner_rst_n,
  output logic               irq
);
  localparam int HALF_AW = CARD_AW / 2;

  logic               accept, is_data, wr_acc;
  logic [HALF_AW-1:0] addr_lo, addr_hi;
  logic               sel_slot, sel_io;
  logic [NSLOT-1:0]   route_q;
  logic [DW-1:0]      ctl2_q;
  logic [NSLOT-1:0]   kick, rst_busy, pres_n;
  logic               pend, irq_en;
  logic               cyc_busy, cyc_done;
  logic [DW-1:0]      cyc_rdata, rd_mux, rsp_q;
  logic               rsp_v_q;
  card_req_t          creq;

  assign req_ready = !cyc_busy;
  assign accept    = req_valid && req_ready;
  assign is_data   = (req_addr == RA_DATA);
  assign wr_acc    = accept && req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_lo  <= '0;
      addr_hi  <= '0;
      sel_slot <= 1'b0;
      sel_io   <= 1'b0;
      route_q  <= '0;
      ctl2_q   <= '0;
    end else if (wr_acc) begin
      case (req_addr)
        RA_ALO:  addr_lo <= req_wdata[DW-1:1];
        RA_AHI:  addr_hi <= req_wdata[HALF_AW-1:0];
        RA_CTL2: ctl2_q  <= req_wdata;
        RA_BUS: begin
          sel_slot   <= req_wdata[7];
          sel_io     <= req_wdata[6];
          route_q[0] <= req_wdata[3];
          route_q[1] <= req_wdata[2];
        end
        default: ;
      endcase
    end
  end

  // Slot reset: bit 5 for slot 0, bit 4 for slot 1
  for (genvar s = 0; s < NSLOT; s++) begin : g_rst
    assign kick[s] = wr_acc && (req_addr == RA_BUS) && req_wdata[5-s];
    cam_slot_reset #(.RST_CYC(RST_CYC)) u_rst (
      .clk(clk), .rst_n(rst_n), .kick(kick[s]),
      .card_rst(card_rst[s]), .busy(rst_busy[s])
    );
  end

  cam_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .det_n(card_detect_n),
    .en_wr(wr_acc && req_addr == RA_IRQ),
    .en_val(req_wdata == IRQ_ARM),
    .ack(accept && !req_write && req_addr == RA_IRQ),
    .present_n(pres_n), .pend(pend), .en(irq_en), .irq(irq)
  );

  assign creq = '{addr: {addr_hi, addr_lo}, wdata: req_wdata,
                  slot: sel_slot, io: sel_io, wr: req_write};

  cam_card_cycle #(.STROBE_CYC(STROBE_CYC)) u_cyc (
    .clk(clk), .rst_n(rst_n), .start(accept && is_data), .req(creq),
    .card_din(card_din), .busy(cyc_busy), .done(cyc_done), .rdata(cyc_rdata),
    .card_addr(card_addr), .card_dout(card_dout), .card_sel_n(card_sel_n),
    .card_io_space(card_io_space), .card_rd_n(card_rd_n), .card_wr_n(card_wr_n)
  );

  always_comb begin
    case (req_addr)
      RA_IRQ:  rd_mux = {1'b0, irq_en, 5'b0, pend};
      RA_CTL2: rd_mux = ctl2_q;
      RA_ALO:  rd_mux = {addr_lo, 1'b0};
      RA_AHI:  rd_mux = {1'b0, addr_hi};
      RA_BUS:  rd_mux = {sel_slot, sel_io, rst_busy[0], rst_busy[1],
                         route_q[0], route_q[1], pres_n[0], pres_n[1]};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_q   <= '0;
    end else begin
      rsp_v_q <= accept && !is_data;
      if (accept && !is_data) rsp_q <= req_write ? '0 : rd_mux;
    end
  end

  assign rsp_valid   = rsp_v_q || cyc_done;
  assign rsp_rdata   = cyc_done ? cyc_rdata : rsp_q;
  assign ts_route_en = route_q;
  assign ts_out_en   = {ctl2_q[5], ctl2_q[4]};
  assign tuner_rst_n = {ctl2_q[2], ctl2_q[3]};

  // R5
  reg_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_data) |=> (rsp_valid && card_rd_n && card_wr_n));
  // R7
  route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_acc && req_addr == RA_BUS) |=> $stable(ts_route_en));
  // R3
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!card_wr_n || !card_rd_n) |-> !req_ready);
endmodule

// File: tb/cam_slot_ctrl_tb_top.sv
module cam_slot_ctrl_tb_top;
  localparam int STROBE = 3;
  localparam int RSTC   = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, card_io_space, card_rd_n, card_wr_n, irq;
  logic [7:0] rsp_rdata, card_dout, card_din;
  logic [13:0] card_addr;
  logic [1:0] card_sel_n, card_rst, ts_route_en, ts_out_en, tuner_rst_n;
  logic [1:0] card_detect_n = 2'b11;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [7:0] card_model(logic [13:0] a, logic slot, logic io);
    return a[7:0] ^ {a[13:8], 2'b11} ^ (io ? 8'h5A : 8'h00) ^ (slot ? 8'hC3 : 8'h00);
  endfunction

  assign card_din = card_model(card_addr, card_sel_n == 2'b01, card_io_space);

  cam_slot_ctrl #(.STROBE_CYC(STROBE), .RST_CYC(RSTC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .card_addr(card_addr),
    .card_dout(card_dout), .card_din(card_din), .card_sel_n(card_sel_n),
    .card_io_space(card_io_space), .card_rd_n(card_rd_n), .card_wr_n(card_wr_n),
    .card_rst(card_rst), .card_detect_n(card_detect_n), .ts_route_en(ts_route_en),
    .ts_out_en(ts_out_en), .tuner_rst_n(tuner_rst_n), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // observed during the last access
  int lat, rd_lows, wr_lows, busy_ready;
  logic [7:0] o_dout, o_rdata;
  logic [13:0] o_addr;
  logic [1:0] o_sel;
  logic o_io;

  task automatic access(input logic wr, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; rd_lows = 0; wr_lows = 0; busy_ready = 0;
    o_sel = 2'b11;
    while (!rsp_valid && lat < 100) begin
      if (!card_rd_n) rd_lows++;
      if (!card_wr_n) begin wr_lows++; o_dout = card_dout; end
      if ((!card_rd_n || !card_wr_n) && req_ready) busy_ready++;
      if (card_sel_n != 2'b11) begin o_sel = card_sel_n; o_addr = card_addr; o_io = card_io_space; end
      @(negedge clk);
      lat++;
    end
    o_rdata = rsp_rdata;
  endtask

  logic [13:0] t_addr;
  logic t_slot, t_io;
  logic [1:0] t_route;

  task automatic set_bus(input logic slot, input logic io);
    t_slot = slot; t_io = io;
    access(1'b1, 4'h7, {slot, io, 2'b00, t_route[0], t_route[1], 2'b00});
  endtask

  task automatic set_addr(input logic [13:0] a);
    t_addr = a;
    access(1'b1, 4'h4, {a[6:0], 1'b0});
    access(1'b1, 4'h5, {1'b0, a[13:7]});
  endtask

  initial begin
    int n;
    void'($urandom(32'd2024));
    t_route = 2'b00;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(req_ready && card_sel_n == 2'b11 && card_rd_n && card_wr_n && !irq, "R11 idle outputs",
        {req_ready, card_sel_n, card_rd_n, card_wr_n, irq}, 6'b111110);
    chk(card_rst == 2'b00 && tuner_rst_n == 2'b00 && ts_out_en == 2'b00 && ts_route_en == 2'b00,
        "R11 control outputs", {card_rst, tuner_rst_n, ts_out_en, ts_route_en}, 0);
    access(1'b0, 4'h7, 8'h00);
    chk(o_rdata == 8'h03, "R11 R8 bus-control reset value", o_rdata, 8'h03);

    // R1 address readback
    set_addr(14'h2A5B);
    access(1'b0, 4'h4, 8'h00);
    chk(o_rdata == {t_addr[6:0], 1'b0}, "R1 low address readback", o_rdata, {t_addr[6:0], 1'b0});
    chk(lat == 1 && rd_lows == 0, "R5 register latency", lat, 1);
    access(1'b0, 4'h5, 8'h00);
    chk(o_rdata == {1'b0, t_addr[13:7]}, "R1 high address readback", o_rdata, {1'b0, t_addr[13:7]});

    // R7 route enables
    t_route = 2'b01;
    set_bus(1'b0, 1'b0);
    chk(ts_route_en == 2'b01, "R7 route slot0", ts_route_en, 2'b01);
    access(1'b0, 4'h7, 8'h00);
    chk(o_rdata == 8'h0B, "R7 route readback", o_rdata, 8'h0B);
    t_route = 2'b10;
    set_bus(1'b0, 1'b0);
    chk(ts_route_en == 2'b10, "R7 route slot1", ts_route_en, 2'b10);

    // R10 second control
    access(1'b1, 4'h1, 8'h38);
    chk(ts_out_en == 2'b11 && tuner_rst_n == 2'b01, "R10 outputs", {ts_out_en, tuner_rst_n}, 4'b1101);
    access(1'b0, 4'h1, 8'h00);
    chk(o_rdata == 8'h38, "R10 readback", o_rdata, 8'h38);

    // R5 unmapped
    access(1'b1, 4'hB, 8'hFF);
    chk(lat == 1 && rd_lows == 0 && wr_lows == 0, "R5 unmapped write no strobe", lat, 1);
    access(1'b0, 4'hB, 8'h00);
    chk(o_rdata == 8'h00, "R5 unmapped reads zero", o_rdata, 0);

    // R3 R4 random card cycles
    for (int i = 0; i < 40; i++) begin
      logic [13:0] a;
      logic [7:0] d;
      logic wr, s, io;
      a = 14'($urandom()); d = 8'($urandom()); wr = 1'($urandom()); s = 1'($urandom()); io = 1'($urandom());
      if (i == 0) a = 14'h3FFF;
      if (i == 1) a = 14'h0000;
      set_addr(a);
      set_bus(s, io);
      access(wr, 4'h6, d);
      chk(o_addr == a, "R1 card address", o_addr, a);
      chk(o_sel == (s ? 2'b01 : 2'b10) && o_io == io, "R2 slot and space", {o_sel, o_io}, {(s ? 2'b01 : 2'b10), io});
      chk(busy_ready == 0, "R3 ready low during strobe", busy_ready, 0);
      if (wr) begin
        chk(wr_lows == STROBE && rd_lows == 0, "R3 write strobe width", {wr_lows, rd_lows}, {STROBE, 0});
        chk(o_dout == d, "R3 write data", o_dout, d);
      end else begin
        chk(rd_lows == STROBE && wr_lows == 0, "R4 read strobe width", {rd_lows, wr_lows}, {STROBE, 0});
        chk(lat == STROBE + 1, "R4 response latency", lat, STROBE + 1);
        chk(o_rdata == card_model(a, s, io), "R4 read data", o_rdata, card_model(a, s, io));
      end
    end
    // R1 address registers unchanged by the card cycles
    access(1'b0, 4'h5, 8'h00);
    chk(o_rdata == {1'b0, t_addr[13:7]}, "R1 address held", o_rdata, {1'b0, t_addr[13:7]});

    // R6 slot 1 reset with readback during pulse
    set_bus(1'b0, 1'b0);
    access(1'b1, 4'h7, 8'h10);
    chk(card_rst == 2'b10, "R6 slot1 reset asserted", card_rst, 2'b10);
    access(1'b0, 4'h7, 8'h00);
    chk(o_rdata[4] == 1'b1 && o_rdata[5] == 1'b0, "R6 busy bit reads 1", o_rdata, 8'h10);
    repeat (RSTC + 2) @(negedge clk);
    access(1'b0, 4'h7, 8'h00);
    chk(o_rdata[5:4] == 2'b00 && card_rst == 2'b00, "R6 busy clears", {o_rdata[5:4], card_rst}, 0);
    // R6 slot 0 pulse width
    access(1'b1, 4'h7, 8'h20);
    n = 0;
    while (card_rst[0] && n < 1000) begin n++; @(negedge clk); end
    chk(n == RSTC, "R6 slot0 pulse width", n, RSTC);
    access(1'b1, 4'h7, 8'h00);
    chk(card_rst == 2'b00, "R6 writing zero no effect", card_rst, 0);

    // R8 R9 presence and interrupt
    access(1'b1, 4'h0, 8'h44);
    chk(!irq, "R9 no pending yet", irq, 0);
    card_detect_n = 2'b10;
    repeat (5) @(negedge clk);
    chk(irq, "R9 irq on detect change", irq, 1);
    access(1'b0, 4'h7, 8'h00);
    chk(o_rdata[1:0] == 2'b01, "R8 presence slot0", o_rdata[1:0], 2'b01);
    access(1'b0, 4'h0, 8'h00);
    chk(o_rdata == 8'h41, "R9 irq register read", o_rdata, 8'h41);
    chk(!irq, "R9 ack clears", irq, 0);
    access(1'b1, 4'h0, 8'h00);
    card_detect_n = 2'b00;
    repeat (5) @(negedge clk);
    chk(!irq, "R9 disabled irq stays low", irq, 0);
    access(1'b0, 4'h0, 8'h00);
    chk(o_rdata == 8'h01, "R9 pending without enable", o_rdata, 8'h01);
    access(1'b0, 4'h7, 8'h00);
    chk(o_rdata[1:0] == 2'b00, "R8 presence both", o_rdata[1:0], 2'b00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R11 watchdog expired: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule